// File: doc/BRIEF.md
# Bidirectional Timer Counter

The block is an 8-bit timer counter that advances once per timer tick. A tick comes from a free-running 10-bit prescaler. A 3-bit clock-select input chooses the prescale ratio, and the zero code stops the counter.

A 2-bit mode input chooses how each tick moves the count:
- free up-counting with wrap-around;
- up/down counting that turns around at both ends;
- clear-on-match against a compare value;
- manual control, where external step, direction and clear inputs act on each tick.

A host write port loads the count at any time. It takes priority over whatever the tick would have done in the same cycle. The block drives the following outputs:
- the count;
- a maximum indicator and a zero indicator;
- a sticky overflow flag;
- an interrupt request, which is the flag gated by an enable.

The flag is cleared by a write-one strobe or by an interrupt acknowledge.

Top module: `bidir_tick_counter`

## Requirements
- R1: After reset the count is 0, the zero indicator is 1, the maximum indicator is 0, and the overflow flag and interrupt request are 0.
- R2: With clock-select code 0 no tick occurs and the count holds its value.
- R3: Clock-select codes 1 to 7 give one tick every 1, 8, 32, 64, 128, 256 and 1024 clocks, so any window of N·k clocks at ratio N contains exactly k count steps.
- R4: In mode 0 (up) each tick adds one, the count wraps from 255 to 0, and the overflow flag is set on that wrap.
- R5: In mode 1 (up/down) the counter steps by one and reverses at 255 and at 0: ...254, 255, 254... and ...1, 0, 1.... The overflow flag is set when the count reaches 0, and it is not set at 255.
- R6: In mode 2 (clear-on-match) a tick at count equal to match_val loads 0 and sets the overflow flag. Otherwise the tick adds one.
- R7: In mode 3 (manual) a tick does the following:
  - it clears the count when ext_clear is 1;
  - otherwise it steps the count by one when ext_step is 1, downward if ext_down is 1;
  - otherwise it holds the count.
  A step that wraps in either direction sets the overflow flag.
- R8: A host write (wr_en) loads wr_data on the next edge, whatever the mode, tick or clear inputs. The tick in that cycle has no effect, and it sets no overflow.
- R9: at_top is 1 exactly when the count is 255, and at_bottom is 1 exactly when the count is 0.
- R10: The overflow flag is cleared by ovf_clr or irq_ack. If a set event and a clear arrive in the same cycle, the set wins.
- R11: irq equals the overflow flag ANDed with ovf_ie.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 3 | Tick source: 0 stop, 1..7 divide by 1/8/32/64/128/256/1024 |
| mode | input | 2 | 0 up, 1 up/down, 2 clear-on-match, 3 manual |
| match_val | input | 8 | Compare value for mode 2 |
| ext_step | input | 1 | Manual mode: step on tick |
| ext_down | input | 1 | Manual mode: step downward |
| ext_clear | input | 1 | Manual mode: clear on tick |
| wr_en | input | 1 | Host write strobe for the count |
| wr_data | input | 8 | Host write data |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears the overflow flag |
| ovf_ie | input | 1 | Overflow interrupt enable |
| count | output | 8 | Current count |
| at_top | output | 1 | Count equals 255 |
| at_bottom | output | 1 | Count equals 0 |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench drives each mode across its turning points: the 255-to-0 wrap, the reversal at both ends in up/down mode, the match clear, and a manual step down from zero.

- A design that reversed one count late would show 0 or 255 twice.
- A design that set the flag at the top in up/down mode would raise a spurious overflow.

The bench also writes the count in the very cycle a tick would wrap it, or a manual clear would zero it. A design with the wrong priority would show the ticked value or a stray overflow. Prescale ratios are measured over exact multi-period windows, which exposes a wrong divider tap. Same-cycle set-and-clear of the flag shows whether a pending event can be lost.

// File: rtl/bidir_tick_counter.sv
module bidir_tick_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   clk_sel,
  input  logic [1:0]   mode,
  input  logic [W-1:0] match_val,
  input  logic         ext_step,
  input  logic         ext_down,
  input  logic         ext_clear,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         ovf_clr,
  input  logic         irq_ack,
  input  logic         ovf_ie,
  output logic [W-1:0] count,
  output logic         at_top,
  output logic         at_bottom,
  output logic         ovf_flag,
  output logic         irq
);
  localparam int PW = 10;
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [PW-1:0] pre;
  logic          tick;
  logic [W-1:0]  cnt, nxt;
  logic          dn, nxt_dn, go_up, wrap, set_ovf;

  always_ff @(posedge clk) begin
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;
  end

  always_comb begin
    case (clk_sel)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &pre[2:0];
      3'd3:    tick = &pre[4:0];
      3'd4:    tick = &pre[5:0];
      3'd5:    tick = &pre[6:0];
      3'd6:    tick = &pre[7:0];
      3'd7:    tick = &pre[9:0];
      default: tick = 1'b0;
    endcase
  end

  assign at_top    = (cnt == MAXV);
  assign at_bottom = (cnt == '0);
  assign go_up     = at_bottom | (~at_top & ~dn);

  always_comb begin
    nxt    = cnt;
    nxt_dn = dn;
    wrap   = 1'b0;
    case (mode)
      2'd0: begin
        nxt  = cnt + ONE;
        wrap = at_top;
      end
      2'd1: begin
        nxt    = go_up ? cnt + ONE : cnt - ONE;
        nxt_dn = ~go_up;
        wrap   = ~go_up & (cnt == ONE);
      end
      2'd2: begin
        if (cnt == match_val) begin
          nxt  = '0;
          wrap = 1'b1;
        end else begin
          nxt  = cnt + ONE;
          wrap = at_top;
        end
      end
      default: begin
        if (ext_clear) nxt = '0;
        else if (ext_step) begin
          nxt  = ext_down ? cnt - ONE : cnt + ONE;
          wrap = ext_down ? at_bottom : at_top;
        end
      end
    endcase
  end

  assign set_ovf = tick & ~wr_en & wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      dn  <= 1'b0;
    end else if (wr_en) begin
      cnt <= wr_data;
    end else if (tick) begin
      cnt <= nxt;
      dn  <= nxt_dn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  ovf_flag <= 1'b0;
    else if (set_ovf)            ovf_flag <= 1'b1;
    else if (ovf_clr | irq_ack)  ovf_flag <= 1'b0;
  end

  assign count = cnt;
  assign irq   = ovf_flag & ovf_ie;

  assert_stop_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0 && !wr_en) |=> $stable(count));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count == $past(wr_data)));

  assert_up_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && mode == 2'd0 && at_top) |=> (count == '0 && ovf_flag));

  assert_bounce_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && mode == 2'd1 && at_top) |=> (count == MAXV - ONE));

  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && clk_sel == 3'd0) |=> !ovf_flag);
endmodule

// File: tb/tb_bidir_tick_counter.sv
module tb_bidir_tick_counter;
  logic clk = 0, rst_n = 0;
  logic [2:0] clk_sel = 0;
  logic [1:0] mode = 0;
  logic [7:0] match_val = 0, wr_data = 0;
  logic ext_step = 0, ext_down = 0, ext_clear = 0, wr_en = 0;
  logic ovf_clr = 0, irq_ack = 0, ovf_ie = 0;
  logic [7:0] count;
  logic at_top, at_bottom, ovf_flag, irq;
  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  bidir_tick_counter dut (.*);

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic load(input logic [7:0] v, input logic clr);
    wr_en = 1; wr_data = v; ovf_clr = clr;
    cyc();
    wr_en = 0; ovf_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 at_bottom", at_bottom, 1);
    chk("R1 at_top", at_top, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_stop();
    clk_sel = 0; mode = 0;
    repeat (20) cyc();
    chk("R2 hold", count, 0);
    load(8'h5A, 0);
    repeat (5) cyc();
    chk("R2 hold after write", count, 8'h5A);
  endtask

  task automatic t_div(input logic [2:0] code, input int n, input int k);
    int c0;
    mode = 0; clk_sel = code;
    cyc();
    c0 = count;
    repeat (n * k) cyc();
    chk($sformatf("R3 ratio code %0d", code), (count - c0) & 255, k);
    clk_sel = 0;
  endtask

  task automatic t_up();
    mode = 0; clk_sel = 0;
    load(253, 1);
    clk_sel = 1;
    cyc(); chk("R4 step", count, 254);
    cyc(); chk("R4 at 255", count, 255); chk("R9 at_top", at_top, 1);
    chk("R4 no ovf yet", ovf_flag, 0);
    cyc(); chk("R4 wrap", count, 0); chk("R4 ovf set", ovf_flag, 1);
    chk("R9 at_bottom", at_bottom, 1);
    clk_sel = 0;
  endtask

  task automatic t_updown();
    mode = 1; clk_sel = 0;
    load(253, 1);
    clk_sel = 1;
    cyc(); chk("R5 up", count, 254);
    cyc(); chk("R5 top", count, 255);
    cyc(); chk("R5 turn at top", count, 254);
    chk("R5 no ovf at top", ovf_flag, 0);
    cyc(); chk("R5 down", count, 253);
    load(2, 1);
    chk("R5 load", count, 2);
    cyc(); chk("R5 down to 1", count, 1);
    cyc(); chk("R5 bottom", count, 0); chk("R5 ovf at bottom", ovf_flag, 1);
    cyc(); chk("R5 turn at bottom", count, 1);
    cyc(); chk("R5 up again", count, 2);
    clk_sel = 0;
  endtask

  task automatic t_match();
    mode = 2; match_val = 5; clk_sel = 1;
    load(3, 1);
    cyc(); chk("R6 step", count, 4);
    cyc(); chk("R6 at match", count, 5); chk("R6 no ovf", ovf_flag, 0);
    cyc(); chk("R6 clear", count, 0); chk("R6 ovf", ovf_flag, 1);
    cyc(); chk("R6 restart", count, 1);
    clk_sel = 0;
  endtask

  task automatic t_manual();
    mode = 3; clk_sel = 1; ext_step = 0;
    load(10, 1);
    cyc(); chk("R7 hold", count, 10);
    ext_step = 1; ext_down = 0;
    cyc(); chk("R7 up", count, 11);
    ext_down = 1;
    cyc(); chk("R7 down", count, 10);
    ext_clear = 1;
    cyc(); chk("R7 clear", count, 0); chk("R7 clear no ovf", ovf_flag, 0);
    ext_clear = 0;
    cyc(); chk("R7 down wrap", count, 255); chk("R7 wrap ovf", ovf_flag, 1);
    ext_step = 0; ext_down = 0; clk_sel = 0;
  endtask

  task automatic t_priority();
    mode = 0; clk_sel = 1;
    load(100, 1);
    chk("R8 write over tick", count, 100);
    load(255, 0);
    load(40, 0);
    chk("R8 write at wrap", count, 40);
    chk("R8 no ovf", ovf_flag, 0);
    mode = 3; ext_clear = 1;
    load(77, 0);
    chk("R8 write over clear", count, 77);
    ext_clear = 0; clk_sel = 0; mode = 0;
  endtask

  task automatic t_flag();
    mode = 0; clk_sel = 1;
    load(255, 1);
    cyc(); chk("R10 set", ovf_flag, 1);
    clk_sel = 0; ovf_clr = 1;
    cyc(); ovf_clr = 0;
    chk("R10 clr", ovf_flag, 0);
    clk_sel = 1;
    load(255, 0);
    cyc(); clk_sel = 0;
    irq_ack = 1;
    cyc(); irq_ack = 0;
    chk("R10 ack", ovf_flag, 0);
    clk_sel = 1;
    load(255, 0);
    ovf_clr = 1;
    cyc(); ovf_clr = 0; clk_sel = 0;
    chk("R10 set wins", ovf_flag, 1);
    ovf_ie = 1; #1;
    chk("R11 irq on", irq, 1);
    ovf_ie = 0; #1;
    chk("R11 irq gated", irq, 0);
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    t_reset();
    t_stop();
    t_div(1, 1, 5);
    t_div(2, 8, 4);
    t_div(4, 64, 3);
    t_div(7, 1024, 2);
    t_up();
    t_updown();
    t_match();
    t_manual();
    t_priority();
    t_flag();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule